// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits between instruction fetch and decode. It takes one 32-bit fetch word and looks at the two lowest bits to find the instruction length. When both bits are set, the word is a full-length instruction and goes through untouched. Any other value means the lower halfword is a 16-bit compressed instruction from the 64-bit compressed subset, which includes the double-precision float load and store forms. The block rewrites that halfword into the equivalent 32-bit base encoding, so decode only ever sees one format.

The rewrite has four parts. It reassembles the scrambled immediate fields into their base-format positions. It widens 3-bit register selectors to full register numbers. It supplies the implied x0, x1 or x2 operands. It also detects reserved compressed encodings and reports them on a separate illegal output. The unit is purely combinational, so each result depends only on the present fetch word.

Top module: `cinst_expand`

## Requirements
- R1: When fetch bits [1:0] are 2'b11, `full_len` is 1, `bad_enc` is 0 and `base_word` equals `fetch_word`.
- R2: For any other value of bits [1:0], `full_len` is 0 and bits [31:16] of `fetch_word` have no effect on `base_word` or `bad_enc`.
- R3: A 3-bit compressed register field (bits [4:2] or [9:7]) is widened to register number 8 + field.
- R4: Quadrant 0, funct3 000 becomes ADDI rd', x2, uimm with uimm[5:4]=[12:11], [9:6]=[10:7], [2]=bit 6, [3]=bit 5. A zero uimm is illegal.
- R5: Quadrant 0 loads and stores (32-bit word, 64-bit doubleword, double float) use base rs1' from [9:7]. The register at [4:2] is the destination for loads and the store data for stores. Word offsets are [6]=bit 5, [5:3]=[12:10], [2]=bit 6. Doubleword offsets are [7:6]=[6:5], [5:3]=[12:10]. Funct3 100 in quadrant 0 is illegal.
- R6: Quadrant 1 funct3 000/010 become ADDI rd, rd, imm6 and ADDI rd, x0, imm6. Funct3 001 becomes ADDIW rd, rd, imm6, and is illegal when rd is 0. imm6 is {bit 12, [6:2]} sign-extended.
- R7: Quadrant 1 funct3 011 with rd=2 becomes ADDI x2, x2, imm with imm[9]=bit 12, [8:7]=[4:3], [6]=bit 5, [5]=bit 2, [4]=bit 6, sign-extended. A zero imm is illegal. With any other rd it becomes LUI rd, sext(imm6). rd=0 or a zero imm6 is illegal.
- R8: Quadrant 1 funct3 100 gives SRLI, SRAI and ANDI on rd' with a 6-bit amount {bit 12,[6:2]}. It also gives SUB, XOR, OR, AND, SUBW and ADDW on rd', rs2'. The two word-form reserved codes are illegal.
- R9: Quadrant 1 funct3 101 becomes JAL x0 with offset [11]=12, [10]=8, [9:8]=[10:9], [7]=6, [6]=7, [5]=2, [4]=11, [3:1]=[5:3], sign-extended.
- R10: Quadrant 1 funct3 110/111 become BEQ/BNE rs1', x0 with offset [8]=12, [7:6]=[6:5], [5]=2, [4:3]=[11:10], [2:1]=[4:3], sign-extended.
- R11: Quadrant 2 funct3 100 gives JALR x0,0(rs1) or JALR x1,0(rs1) when [6:2] is 0 and rs1 is nonzero, where rs1=0 is illegal. The exception is bit 12 set with rs1=0, which gives EBREAK. Otherwise it gives ADD rd, x0, rs2 (bit 12 clear) or ADD rd, rd, rs2 (bit 12 set). Funct3 000 gives SLLI rd, rd, {bit 12,[6:2]}.
- R12: Quadrant 2 stack loads and stores use base x2. Word load offsets are [7:6]=[3:2], [5]=12, [4:2]=[6:4]. Doubleword and float loads use [8:6]=[4:2], [5]=12, [4:3]=[6:5]. Word stores use [7:6]=[8:7], [5:2]=[12:9]. Doubleword stores use [8:6]=[9:7], [5:3]=[12:10]. Stack integer loads with rd=0 are illegal.
- R13: When `bad_enc` is 1, `base_word` is all zeros and `full_len` is 0. The all-zero halfword is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fetch_word | input | 32 | Fetched word; lower halfword holds a compressed instruction when bits [1:0] are not 2'b11 |
| base_word | output | 32 | Equivalent full-length instruction encoding, or zero when illegal |
| full_len | output | 1 | 1 when the input is a full-length instruction |
| bad_enc | output | 1 | 1 when the compressed halfword is reserved or unassigned |

## Verification
Every output is combinational, so each result is due in the same cycle its fetch word is applied, with no register in between. The driver applies a word and queues its expected result on a falling clock edge. The monitor takes that item from the queue and compares it on the following rising edge, half a period later, when the inputs have been stable since the last change. The stimulus covers each compressed form with offsets chosen to set one scattered bit at a time, the extremes of the signed ranges, and each reserved case next to a legal neighbour.

// File: rtl/cinst_pkg.sv
package cinst_pkg;
  localparam int ILEN = 32;
  localparam int CLEN = 16;
  localparam int RW   = 5;
  localparam int CRW  = 3;

  localparam logic [6:0] OP_LOAD     = 7'b0000011;
  localparam logic [6:0] OP_LOAD_FP  = 7'b0000111;
  localparam logic [6:0] OP_IMM      = 7'b0010011;
  localparam logic [6:0] OP_IMM32    = 7'b0011011;
  localparam logic [6:0] OP_STORE    = 7'b0100011;
  localparam logic [6:0] OP_STORE_FP = 7'b0100111;
  localparam logic [6:0] OP_REG      = 7'b0110011;
  localparam logic [6:0] OP_LUI      = 7'b0110111;
  localparam logic [6:0] OP_REG32    = 7'b0111011;
  localparam logic [6:0] OP_BRANCH   = 7'b1100011;
  localparam logic [6:0] OP_JALR     = 7'b1100111;
  localparam logic [6:0] OP_JAL      = 7'b1101111;
  localparam logic [ILEN-1:0] WORD_EBREAK = 32'h0010_0073;

  localparam logic [2:0] F3_ADD = 3'b000;
  localparam logic [2:0] F3_SLL = 3'b001;
  localparam logic [2:0] F3_W   = 3'b010;
  localparam logic [2:0] F3_D   = 3'b011;
  localparam logic [2:0] F3_XOR = 3'b100;
  localparam logic [2:0] F3_SRL = 3'b101;
  localparam logic [2:0] F3_OR  = 3'b110;
  localparam logic [2:0] F3_AND = 3'b111;

  localparam logic [RW-1:0] REG_ZERO = 5'd0;
  localparam logic [RW-1:0] REG_LINK = 5'd1;
  localparam logic [RW-1:0] REG_SP   = 5'd2;

  function automatic logic [RW-1:0] widen(input logic [CRW-1:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [ILEN-1:0] mk_i(input logic [11:0] imm, input logic [RW-1:0] rs1,
                                           input logic [2:0] f3, input logic [RW-1:0] rd,
                                           input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [ILEN-1:0] mk_s(input logic [11:0] imm, input logic [RW-1:0] rs2,
                                           input logic [RW-1:0] rs1, input logic [2:0] f3,
                                           input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic logic [ILEN-1:0] mk_r(input logic [6:0] f7, input logic [RW-1:0] rs2,
                                           input logic [RW-1:0] rs1, input logic [2:0] f3,
                                           input logic [RW-1:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  // offset bits [12:1]
  function automatic logic [ILEN-1:0] mk_b(input logic [12:1] off, input logic [RW-1:0] rs1,
                                           input logic [2:0] f3);
    return {off[12], off[10:5], REG_ZERO, rs1, f3, off[4:1], off[11], OP_BRANCH};
  endfunction

  // offset bits [20:1]
  function automatic logic [ILEN-1:0] mk_j(input logic [20:1] off, input logic [RW-1:0] rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, OP_JAL};
  endfunction
endpackage

// File: rtl/cinst_q0.sv
module cinst_q0
  import cinst_pkg::*;
(
  input  logic [CLEN-1:2] hw,
  output logic [ILEN-1:0] word,
  output logic            bad
);
  logic [2:0]    f3;
  logic [RW-1:0] rdp;
  logic [RW-1:0] rs1p;
  logic [9:0]    imm_spn;
  logic [6:0]    off_w;
  logic [7:0]    off_d;

  always_comb begin
    f3      = hw[15:13];
    rdp     = widen(hw[4:2]);
    rs1p    = widen(hw[9:7]);
    imm_spn = {hw[10:7], hw[12:11], hw[5], hw[6], 2'b00};
    off_w   = {hw[5], hw[12:10], hw[6], 2'b00};
    off_d   = {hw[6:5], hw[12:10], 3'b000};
    word    = '0;
    bad     = 1'b0;
    unique case (f3)
      3'b000: begin
        word = mk_i({2'b00, imm_spn}, REG_SP, F3_ADD, rdp, OP_IMM);
        bad  = (imm_spn == '0);
      end
      3'b001: word = mk_i({4'b0, off_d}, rs1p, F3_D, rdp, OP_LOAD_FP);
      3'b010: word = mk_i({5'b0, off_w}, rs1p, F3_W, rdp, OP_LOAD);
      3'b011: word = mk_i({4'b0, off_d}, rs1p, F3_D, rdp, OP_LOAD);
      3'b101: word = mk_s({4'b0, off_d}, rdp, rs1p, F3_D, OP_STORE_FP);
      3'b110: word = mk_s({5'b0, off_w}, rdp, rs1p, F3_W, OP_STORE);
      3'b111: word = mk_s({4'b0, off_d}, rdp, rs1p, F3_D, OP_STORE);
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/cinst_q1.sv
module cinst_q1
  import cinst_pkg::*;
(
  input  logic [CLEN-1:2] hw,
  output logic [ILEN-1:0] word,
  output logic            bad
);
  logic [2:0]    f3;
  logic [RW-1:0] rd;
  logic [RW-1:0] rdp;
  logic [RW-1:0] rs2p;
  logic [5:0]    imm6;
  logic [11:0]   simm;
  logic [9:0]    sp_adj;
  logic [11:1]   joff;
  logic [8:1]    boff;

  always_comb begin
    f3     = hw[15:13];
    rd     = hw[11:7];
    rdp    = widen(hw[9:7]);
    rs2p   = widen(hw[4:2]);
    imm6   = {hw[12], hw[6:2]};
    simm   = {{6{hw[12]}}, imm6};
    sp_adj = {hw[12], hw[4:3], hw[5], hw[2], hw[6], 4'b0000};
    joff   = {hw[12], hw[8], hw[10:9], hw[6], hw[7], hw[2], hw[11], hw[5:3]};
    boff   = {hw[12], hw[6:5], hw[2], hw[11:10], hw[4:3]};
    word   = '0;
    bad    = 1'b0;
    unique case (f3)
      3'b000: word = mk_i(simm, rd, F3_ADD, rd, OP_IMM);
      3'b001: begin
        word = mk_i(simm, rd, F3_ADD, rd, OP_IMM32);
        bad  = (rd == REG_ZERO);
      end
      3'b010: word = mk_i(simm, REG_ZERO, F3_ADD, rd, OP_IMM);
      3'b011: begin
        if (rd == REG_SP) begin
          word = mk_i({{2{hw[12]}}, sp_adj}, REG_SP, F3_ADD, REG_SP, OP_IMM);
          bad  = (sp_adj == '0);
        end else begin
          word = {{14{hw[12]}}, imm6, rd, OP_LUI};
          bad  = (rd == REG_ZERO) || (imm6 == '0);
        end
      end
      3'b100: begin
        unique case (hw[11:10])
          2'b00: word = mk_i({6'b000000, imm6}, rdp, F3_SRL, rdp, OP_IMM);
          2'b01: word = mk_i({6'b010000, imm6}, rdp, F3_SRL, rdp, OP_IMM);
          2'b10: word = mk_i(simm, rdp, F3_AND, rdp, OP_IMM);
          default: begin
            unique case ({hw[12], hw[6:5]})
              3'b000: word = mk_r(7'h20, rs2p, rdp, F3_ADD, rdp, OP_REG);
              3'b001: word = mk_r(7'h00, rs2p, rdp, F3_XOR, rdp, OP_REG);
              3'b010: word = mk_r(7'h00, rs2p, rdp, F3_OR,  rdp, OP_REG);
              3'b011: word = mk_r(7'h00, rs2p, rdp, F3_AND, rdp, OP_REG);
              3'b100: word = mk_r(7'h20, rs2p, rdp, F3_ADD, rdp, OP_REG32);
              3'b101: word = mk_r(7'h00, rs2p, rdp, F3_ADD, rdp, OP_REG32);
              default: bad = 1'b1;
            endcase
          end
        endcase
      end
      3'b101: word = mk_j({{9{hw[12]}}, joff}, REG_ZERO);
      3'b110: word = mk_b({{4{hw[12]}}, boff}, rdp, 3'b000);
      default: word = mk_b({{4{hw[12]}}, boff}, rdp, 3'b001);
    endcase
  end
endmodule

// File: rtl/cinst_q2.sv
module cinst_q2
  import cinst_pkg::*;
(
  input  logic [CLEN-1:2] hw,
  output logic [ILEN-1:0] word,
  output logic            bad
);
  logic [2:0]    f3;
  logic [RW-1:0] rd;
  logic [RW-1:0] rs2;
  logic [7:0]    lw_off;
  logic [8:0]    ld_off;
  logic [7:0]    sw_off;
  logic [8:0]    sd_off;

  always_comb begin
    f3     = hw[15:13];
    rd     = hw[11:7];
    rs2    = hw[6:2];
    lw_off = {hw[3:2], hw[12], hw[6:4], 2'b00};
    ld_off = {hw[4:2], hw[12], hw[6:5], 3'b000};
    sw_off = {hw[8:7], hw[12:9], 2'b00};
    sd_off = {hw[9:7], hw[12:10], 3'b000};
    word   = '0;
    bad    = 1'b0;
    unique case (f3)
      3'b000: word = mk_i({6'b000000, hw[12], hw[6:2]}, rd, F3_SLL, rd, OP_IMM);
      3'b001: word = mk_i({3'b0, ld_off}, REG_SP, F3_D, rd, OP_LOAD_FP);
      3'b010: begin
        word = mk_i({4'b0, lw_off}, REG_SP, F3_W, rd, OP_LOAD);
        bad  = (rd == REG_ZERO);
      end
      3'b011: begin
        word = mk_i({3'b0, ld_off}, REG_SP, F3_D, rd, OP_LOAD);
        bad  = (rd == REG_ZERO);
      end
      3'b100: begin
        if (rs2 == REG_ZERO) begin
          if (hw[12] && (rd == REG_ZERO)) begin
            word = WORD_EBREAK;
          end else begin
            word = mk_i(12'h000, rd, F3_ADD, hw[12] ? REG_LINK : REG_ZERO, OP_JALR);
            bad  = (rd == REG_ZERO);
          end
        end else begin
          word = mk_r(7'h00, rs2, hw[12] ? rd : REG_ZERO, F3_ADD, rd, OP_REG);
        end
      end
      3'b101: word = mk_s({3'b0, sd_off}, rs2, REG_SP, F3_D, OP_STORE_FP);
      3'b110: word = mk_s({4'b0, sw_off}, rs2, REG_SP, F3_W, OP_STORE);
      default: word = mk_s({3'b0, sd_off}, rs2, REG_SP, F3_D, OP_STORE);
    endcase
  end
endmodule

// File: rtl/cinst_expand.sv
module cinst_expand
  import cinst_pkg::*;
(
  input  logic [ILEN-1:0] fetch_word,
  output logic [ILEN-1:0] base_word,
  output logic            full_len,
  output logic            bad_enc
);
  localparam int NQ = 3;

  logic [ILEN-1:0] q_word [NQ];
  logic [NQ-1:0]   q_bad;
  logic [1:0]      quad;

  assign quad = fetch_word[1:0];

  cinst_q0 u_q0 (.hw(fetch_word[CLEN-1:2]), .word(q_word[0]), .bad(q_bad[0]));
  cinst_q1 u_q1 (.hw(fetch_word[CLEN-1:2]), .word(q_word[1]), .bad(q_bad[1]));
  cinst_q2 u_q2 (.hw(fetch_word[CLEN-1:2]), .word(q_word[2]), .bad(q_bad[2]));

  always_comb begin
    full_len  = (quad == 2'b11);
    base_word = fetch_word;
    bad_enc   = 1'b0;
    if (!full_len) begin
      bad_enc   = q_bad[quad];
      base_word = bad_enc ? '0 : q_word[quad];
    end
  end

  // Checks on the expanded output against the fetched bits
  always_comb begin
    if (fetch_word[1:0] == 2'b11)
      assert_wide_pass_R1: assert (base_word == fetch_word && !bad_enc);
    if (bad_enc)
      assert_illegal_zero_R13: assert (base_word == '0 && !full_len);
    if (fetch_word[CLEN-1:0] == '0)
      assert_zero_half_R13: assert (bad_enc);
    if (fetch_word[1:0] == 2'b00 && fetch_word[15:13] == 3'b000 && fetch_word[12:5] == '0)
      assert_spn_zero_R4: assert (bad_enc);
    if (fetch_word[1:0] == 2'b00 && fetch_word[15:13] == 3'b010)
      assert_widen_rs1_R3: assert (base_word[19:15] == {2'b01, fetch_word[9:7]});
    if (fetch_word[1:0] == 2'b01 && fetch_word[15:13] == 3'b011 && fetch_word[11:7] == '0)
      assert_lui_rd0_R7: assert (bad_enc);
    if (fetch_word[1:0] == 2'b10 && fetch_word[15:12] == 4'b1000 &&
        fetch_word[11:2] == '0)
      assert_jr_rs0_R11: assert (bad_enc);
    if (fetch_word[1:0] == 2'b01 && fetch_word[15:14] == 2'b11 && !bad_enc)
      assert_branch_zero_R10: assert (base_word[24:20] == REG_ZERO && base_word[6:0] == OP_BRANCH);
  end
endmodule

// File: tb/cinst_expand_test.sv
`timescale 1ns/1ps
module cinst_expand_test;
  typedef struct packed {
    logic [31:0] stim;
    logic [31:0] word;
    logic        wide;
    logic        ill;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] fetch_word;
  logic [31:0] base_word;
  logic        full_len;
  logic        bad_enc;

  item_t exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  bit    done     = 0;

  cinst_expand uut (
    .fetch_word(fetch_word),
    .base_word (base_word),
    .full_len  (full_len),
    .bad_enc   (bad_enc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic apply(input logic [31:0] s, input logic [31:0] w, input logic wd,
                       input logic il, input string tag);
    item_t it;
    @(negedge clk);
    fetch_word = s;
    it.stim = s; it.word = w; it.wide = wd; it.ill = il;
    exp_q.push_back(it);
    tag_q.push_back(tag);
  endtask

  task automatic c16(input logic [15:0] h, input logic [31:0] w, input string tag);
    apply({16'h0000, h}, w, 1'b0, 1'b0, tag);
  endtask

  task automatic bad16(input logic [15:0] h, input string tag);
    apply({16'h0000, h}, 32'h0, 1'b0, 1'b1, tag);
  endtask

  // monitor: results are combinational, due half a cycle after the driver edge
  always @(posedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      item_t it;
      string tg;
      it = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_checks++;
      if (base_word !== it.word || full_len !== it.wide || bad_enc !== it.ill) begin
        n_fail++;
        $display("FAIL %s in=%h word act=%h exp=%h len act=%b exp=%b ill act=%b exp=%b",
                 tg, it.stim, base_word, it.word, full_len, it.wide, bad_enc, it.ill);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_word = 32'h0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R13: starting state, all-zero halfword
    bad16(16'h0000, "R13 zero halfword");
    // R1: full-length pass-through
    apply(32'h00A5_0513, 32'h00A5_0513, 1'b1, 1'b0, "R1 pass");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R1 pass ones");
    // R2: upper half ignored for compressed input
    apply(32'hDEAD_0515, 32'h0055_0513, 1'b0, 1'b0, "R2 upper ignored");
    apply(32'hFFFF_0000, 32'h0, 1'b0, 1'b1, "R2 upper ignored illegal");
    // R4
    c16(16'h0808, 32'h0101_0513, "R4 addi4spn 16");
    c16(16'h1FE0, 32'h3FC1_0413, "R4 addi4spn max");
    // R3 and R5
    c16(16'h414C, 32'h0045_2583, "R3 R5 lw");
    c16(16'hC12C, 32'h04B5_2023, "R5 sw");
    c16(16'h650C, 32'h0085_3583, "R5 ld");
    c16(16'h614C, 32'h0805_3583, "R5 ld off128");
    c16(16'hE10C, 32'h00B5_3023, "R5 sd");
    c16(16'h210C, 32'h0005_3587, "R5 fld");
    c16(16'hA10C, 32'h00B5_3027, "R5 fsd");
    bad16(16'h8000, "R5 quadrant0 reserved");
    // R6
    c16(16'h0001, 32'h0000_0013, "R6 nop");
    c16(16'h557D, 32'hFFF0_0513, "R6 li -1");
    c16(16'h0515, 32'h0055_0513, "R6 addi");
    c16(16'h2505, 32'h0015_051B, "R6 addiw");
    bad16(16'h2005, "R6 addiw rd0");
    // R7
    c16(16'h7139, 32'hFC01_0113, "R7 addi16sp -64");
    bad16(16'h6101, "R7 addi16sp zero");
    c16(16'h6505, 32'h0000_1537, "R7 lui 1");
    c16(16'h757D, 32'hFFFF_F537, "R7 lui neg");
    bad16(16'h6005, "R7 lui rd0");
    bad16(16'h6501, "R7 lui zero imm");
    // R8
    c16(16'h810D, 32'h0035_5513, "R8 srli");
    c16(16'h9505, 32'h4215_5513, "R8 srai 33");
    c16(16'h9979, 32'hFFE5_7513, "R8 andi");
    c16(16'h8D0D, 32'h40B5_0533, "R8 sub");
    c16(16'h8D6D, 32'h00B5_7533, "R8 and");
    c16(16'h9D2D, 32'h00B5_053B, "R8 addw");
    bad16(16'h9D4D, "R8 reserved word op");
    // R9
    c16(16'hBFFD, 32'hFFFF_F06F, "R9 j -2");
    c16(16'hA005, 32'h0200_006F, "R9 j 32");
    c16(16'hA101, 32'h4000_006F, "R9 j 1024");
    // R10
    c16(16'hC501, 32'h0005_0463, "R10 beqz 8");
    c16(16'hFD75, 32'hFE05_1EE3, "R10 bnez -4");
    // R11
    c16(16'h8082, 32'h0000_8067, "R11 jr ra");
    bad16(16'h8002, "R11 jr x0");
    c16(16'h9502, 32'h0005_00E7, "R11 jalr");
    c16(16'h852E, 32'h00B0_0533, "R11 mv");
    c16(16'h952E, 32'h00B5_0533, "R11 add");
    c16(16'h9002, 32'h0010_0073, "R11 ebreak");
    c16(16'h050A, 32'h0025_1513, "R11 slli");
    // R12
    c16(16'h4532, 32'h00C1_2503, "R12 lwsp");
    bad16(16'h4032, "R12 lwsp rd0");
    c16(16'h6542, 32'h0101_3503, "R12 ldsp 16");
    c16(16'h6506, 32'h0401_3503, "R12 ldsp 64");
    c16(16'hC42E, 32'h00B1_2423, "R12 swsp");
    c16(16'hEC2E, 32'h00B1_3C23, "R12 sdsp");
    c16(16'h2522, 32'h0081_3507, "R12 fldsp");
    c16(16'hA42E, 32'h00B1_3427, "R12 fsdsp");
    // drain
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule